// File: doc/BRIEF.md
# Stereo Peak Limiter

This block sits in a stereo playback path and keeps a signed PCM stream below a programmable ceiling. Each accepted sample pair is scaled by a per-channel gain, and the scaled value is registered onto the output one cycle later. The same scaled value also drives the peak decision. When its magnitude rises above the ceiling, attenuation grows in 0.5 dB steps at the attack pace. When the magnitude drops below a separate, lower cushion level, attenuation shrinks at the release pace. Between the two levels nothing moves, which gives the loop its hysteresis.

Attack and release are each a 6-bit code: a code of c waits c+1 qualifying samples per 0.5 dB step. A link control makes both channels follow one shared decision, so a peak on either side pulls both down by the same amount. While the limiter is enabled it owns the gain path. With the enable low, samples pass through untouched and all limiter state is cleared.

Top module: `pk_limiter`

## Requirements
- R1: After reset, out_valid is 0 and att_l, att_r, out_l and out_r are 0.
- R2: While a channel's attenuation is 0, its output equals its input sample exactly.
- R3: For attenuation a (0.5 dB units), gain G = M[a mod 12] >> (a div 12). The output is floor(x*G/32768), where M = 32768, 30935, 29205, 27571, 26029, 24573, 23198, 21900, 20675, 19519, 18427, 17396.
- R4: On an accepted sample whose scaled magnitude is above the ceiling level, the channel's attack counter advances. Attenuation rises by 1 on every (cfg_attack+1)-th consecutive such sample.
- R5: On an accepted sample whose scaled magnitude is below the cushion level while attenuation is nonzero, attenuation falls by 1 on every (cfg_release+1)-th consecutive such sample.
- R6: A sample whose scaled magnitude lies from the cushion level up to the ceiling holds attenuation and restarts both pacing counters. The levels for cfg_max and cfg_cush codes 0 to 7 are 8388607, 5938687, 4194303, 2969343, 2097151, 1048575, 524287, 262143.
- R7: Attenuation never exceeds 60 (30 dB). Further peaks at 60 leave it unchanged.
- R8: With cfg_link at 0, each channel decides from its own samples only.
- R9: With cfg_link at 1, both channels take one shared decision: attack if either channel is above the ceiling, release only if both are below the cushion. Both attenuations are then equal after every update.
- R10: While cfg_en is 0, outputs equal inputs and both attenuations and all pacing counters are cleared.
- R11: out_valid follows smp_valid by one cycle. Attenuation changes only on cycles where smp_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample pair strobe |
| smp_l | input | 24 | Left sample, two's complement |
| smp_r | input | 24 | Right sample, two's complement |
| cfg_en | input | 1 | Limiter enable |
| cfg_link | input | 1 | Shared decision for both channels |
| cfg_max | input | 3 | Ceiling level code |
| cfg_cush | input | 3 | Cushion level code |
| cfg_attack | input | 6 | Attack pace code |
| cfg_release | input | 6 | Release pace code |
| out_valid | output | 1 | Output pair strobe |
| out_l | output | 24 | Scaled left sample |
| out_r | output | 24 | Scaled right sample |
| att_l | output | 6 | Left attenuation, 0.5 dB units |
| att_r | output | 6 | Right attenuation, 0.5 dB units |

## Verification
The assertions watch properties that hold on every cycle:
- attenuation stays within the 30 dB cap;
- attenuation moves by at most one step per update;
- attenuation stays still without a strobe;
- attenuation is cleared while disabled;
- out_valid is a one-cycle delay of the strobe;
- the two channels are equal whenever link is on;
- the path is exact at zero attenuation.

The scoreboard scenarios cover what only a sequence can show:
- the pacing of steps for different attack and release codes;
- the hold band between cushion and ceiling, including negative peaks;
- the gain law at many attenuation values;
- the independence of unlinked channels;
- the clamp under a sustained full-scale negative input.

// File: rtl/pk_limiter.sv
module pk_limiter #(
  parameter int DW      = 24,
  parameter int AW      = 6,
  parameter int RW      = 6,
  parameter int ATT_MAX = 60
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic signed [DW-1:0] smp_l,
  input  logic signed [DW-1:0] smp_r,
  input  logic                 cfg_en,
  input  logic                 cfg_link,
  input  logic [2:0]           cfg_max,
  input  logic [2:0]           cfg_cush,
  input  logic [RW-1:0]        cfg_attack,
  input  logic [RW-1:0]        cfg_release,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_l,
  output logic signed [DW-1:0] out_r,
  output logic [AW-1:0]        att_l,
  output logic [AW-1:0]        att_r
);

  localparam int MW = 16;
  localparam int PW = DW + MW + 1;
  localparam logic [DW-1:0] FS = {1'b0, {(DW-1){1'b1}}};

  function automatic logic [MW-1:0] mant(input logic [3:0] k);
    case (k)
      4'd0:    mant = MW'(32768);
      4'd1:    mant = MW'(30935);
      4'd2:    mant = MW'(29205);
      4'd3:    mant = MW'(27571);
      4'd4:    mant = MW'(26029);
      4'd5:    mant = MW'(24573);
      4'd6:    mant = MW'(23198);
      4'd7:    mant = MW'(21900);
      4'd8:    mant = MW'(20675);
      4'd9:    mant = MW'(19519);
      4'd10:   mant = MW'(18427);
      default: mant = MW'(17396);
    endcase
  endfunction

  function automatic logic [DW-1:0] level(input logic [2:0] c);
    logic [DW+MW-1:0] m3;
    m3 = ({{MW{1'b0}}, FS} * (DW+MW)'(23198)) >> 15;
    case (c)
      3'd0:    level = FS;
      3'd1:    level = m3[DW-1:0];
      3'd2:    level = FS >> 1;
      3'd3:    level = m3[DW-1:0] >> 1;
      3'd4:    level = FS >> 2;
      3'd5:    level = FS >> 3;
      3'd6:    level = FS >> 4;
      default: level = FS >> 5;
    endcase
  endfunction

  logic signed [DW-1:0] x [2];
  logic signed [DW-1:0] y [2];
  logic signed [PW-1:0] p [2];
  logic [MW-1:0]        g [2];
  logic [DW-1:0]        mag [2];
  logic                 ovr [2], und [2], o_sel [2], u_sel [2];
  logic [AW-1:0]        att_q [2], att_d [2];
  logic [RW-1:0]        ac_q [2], ac_d [2], rc_q [2], rc_d [2];

  assign x[0]  = smp_l;
  assign x[1]  = smp_r;
  assign att_l = att_q[0];
  assign att_r = att_q[1];

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      g[c]   = mant(4'(att_q[c] % 12)) >> (att_q[c] / 12);
      p[c]   = x[c] * $signed({1'b0, g[c]});
      y[c]   = DW'(p[c] >>> 15);
      mag[c] = y[c][DW-1] ? DW'(-y[c]) : DW'(y[c]);
      ovr[c] = mag[c] > level(cfg_max);
      und[c] = mag[c] < level(cfg_cush);
    end
  end

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      int s;
      s        = cfg_link ? 0 : c;
      o_sel[c] = cfg_link ? (ovr[0] | ovr[1]) : ovr[c];
      u_sel[c] = cfg_link ? (und[0] & und[1]) : und[c];
      att_d[c] = att_q[s];
      ac_d[c]  = ac_q[s];
      rc_d[c]  = rc_q[s];
      if (o_sel[c]) begin
        rc_d[c] = '0;
        if (ac_q[s] >= cfg_attack) begin
          ac_d[c] = '0;
          if (int'(att_q[s]) < ATT_MAX) att_d[c] = att_q[s] + 1'b1;
        end else begin
          ac_d[c] = ac_q[s] + 1'b1;
        end
      end else if (u_sel[c] && att_q[s] != '0) begin
        ac_d[c] = '0;
        if (rc_q[s] >= cfg_release) begin
          rc_d[c]  = '0;
          att_d[c] = att_q[s] - 1'b1;
        end else begin
          rc_d[c] = rc_q[s] + 1'b1;
        end
      end else begin
        ac_d[c] = '0;
        rc_d[c] = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_l     <= '0;
      out_r     <= '0;
      for (int c = 0; c < 2; c++) begin
        att_q[c] <= '0;
        ac_q[c]  <= '0;
        rc_q[c]  <= '0;
      end
    end else begin
      out_valid <= smp_valid;
      if (smp_valid) begin
        out_l <= cfg_en ? y[0] : x[0];
        out_r <= cfg_en ? y[1] : x[1];
      end
      for (int c = 0; c < 2; c++) begin
        if (!cfg_en) begin
          att_q[c] <= '0;
          ac_q[c]  <= '0;
          rc_q[c]  <= '0;
        end else if (smp_valid) begin
          att_q[c] <= att_d[c];
          ac_q[c]  <= ac_d[c];
          rc_q[c]  <= rc_d[c];
        end
      end
    end
  end

endmodule

// File: rtl/pk_limiter_chk.sv
module pk_limiter_chk #(
  parameter int DW      = 24,
  parameter int AW      = 6,
  parameter int ATT_MAX = 60
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_valid,
  input logic signed [DW-1:0] smp_l,
  input logic signed [DW-1:0] smp_r,
  input logic                 cfg_en,
  input logic                 cfg_link,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_l,
  input logic signed [DW-1:0] out_r,
  input logic [AW-1:0]        att_l,
  input logic [AW-1:0]        att_r
);

  p_att_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(att_l) <= ATT_MAX && int'(att_r) <= ATT_MAX);

  p_one_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_en) |-> ((int'(att_l) - int'($past(att_l))) <= 1 &&
                       (int'(att_l) - int'($past(att_l))) >= -1 &&
                       (int'(att_r) - int'($past(att_r))) <= 1 &&
                       (int'(att_r) - int'($past(att_r))) >= -1));

  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid && cfg_en) |=> ($stable(att_l) && $stable(att_r)));

  p_valid_hi_r11: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> out_valid);

  p_valid_lo_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !out_valid);

  p_off_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (att_l == '0 && att_r == '0));

  p_linked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_link && cfg_en) |=> (att_l == att_r));

  p_unity_l_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && att_l == '0) |=> (out_l == $past(smp_l)));

  p_unity_r_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && att_r == '0) |=> (out_r == $past(smp_r)));

endmodule

bind pk_limiter pk_limiter_chk #(.DW(DW), .AW(AW), .ATT_MAX(ATT_MAX)) chk_i (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_l(smp_l), .smp_r(smp_r),
  .cfg_en(cfg_en), .cfg_link(cfg_link), .out_valid(out_valid), .out_l(out_l),
  .out_r(out_r), .att_l(att_l), .att_r(att_r)
);

// File: tb/pk_limiter_tb_top.sv
module pk_limiter_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic signed [23:0] smp_l = '0, smp_r = '0;
  logic cfg_en = 1'b0, cfg_link = 1'b0;
  logic [2:0] cfg_max = '0, cfg_cush = '0;
  logic [5:0] cfg_attack = '0, cfg_release = '0;
  logic out_valid;
  logic signed [23:0] out_l, out_r;
  logic [5:0] att_l, att_r;

  always #4 clk = ~clk;

  pk_limiter dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_l(smp_l), .smp_r(smp_r),
    .cfg_en(cfg_en), .cfg_link(cfg_link), .cfg_max(cfg_max), .cfg_cush(cfg_cush),
    .cfg_attack(cfg_attack), .cfg_release(cfg_release), .out_valid(out_valid),
    .out_l(out_l), .out_r(out_r), .att_l(att_l), .att_r(att_r)
  );

  typedef struct {
    longint el;
    longint er;
    int     al;
    int     ar;
    string  tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int mant_tab[12] = '{32768, 30935, 29205, 27571, 26029, 24573,
                       23198, 21900, 20675, 19519, 18427, 17396};
  int lvl_tab[8]   = '{8388607, 5938687, 4194303, 2969343,
                       2097151, 1048575, 524287, 262143};

  int m_att[2], m_ac[2], m_rc[2];

  function automatic int gain(int a);
    return mant_tab[a % 12] >> (a / 12);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic send(input int l, input int r, input string tag);
    longint y[2], mag;
    int xs[2], na[2], nac[2], nrc[2];
    bit o[2], u[2], os, us;
    exp_t it;
    xs[0] = l;
    xs[1] = r;
    @(negedge clk);
    smp_valid = 1'b1;
    smp_l = 24'(l);
    smp_r = 24'(r);
    for (int c = 0; c < 2; c++) begin
      y[c] = cfg_en ? ((longint'(xs[c]) * gain(m_att[c])) >>> 15) : longint'(xs[c]);
      mag  = (y[c] < 0) ? -y[c] : y[c];
      o[c] = mag > lvl_tab[cfg_max];
      u[c] = mag < lvl_tab[cfg_cush];
    end
    for (int c = 0; c < 2; c++) begin
      int s;
      s  = cfg_link ? 0 : c;
      os = cfg_link ? (o[0] | o[1]) : o[c];
      us = cfg_link ? (u[0] & u[1]) : u[c];
      na[c] = m_att[s]; nac[c] = m_ac[s]; nrc[c] = m_rc[s];
      if (!cfg_en) begin
        na[c] = 0; nac[c] = 0; nrc[c] = 0;
      end else if (os) begin
        nrc[c] = 0;
        if (m_ac[s] >= cfg_attack) begin
          nac[c] = 0;
          if (m_att[s] < 60) na[c] = m_att[s] + 1;
        end else nac[c] = m_ac[s] + 1;
      end else if (us && m_att[s] != 0) begin
        nac[c] = 0;
        if (m_rc[s] >= cfg_release) begin
          nrc[c] = 0;
          na[c] = m_att[s] - 1;
        end else nrc[c] = m_rc[s] + 1;
      end else begin
        nac[c] = 0; nrc[c] = 0;
      end
    end
    for (int c = 0; c < 2; c++) begin
      m_att[c] = na[c]; m_ac[c] = nac[c]; m_rc[c] = nrc[c];
    end
    it.el = y[0]; it.er = y[1]; it.al = m_att[0]; it.ar = m_att[1]; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R11 unexpected out_valid", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(longint'(out_l) == e.el && longint'(out_r) == e.er &&
            int'(att_l) == e.al && int'(att_r) == e.ar, {e.tag, " out_l"},
            longint'(out_l), e.el);
        if (longint'(out_r) != e.er || int'(att_l) != e.al || int'(att_r) != e.ar)
          $display("  detail %s: out_r=%0d/%0d att_l=%0d/%0d att_r=%0d/%0d", e.tag,
                   out_r, e.er, att_l, e.al, att_r, e.ar);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int a0, b0;
    for (int c = 0; c < 2; c++) begin m_att[c] = 0; m_ac[c] = 0; m_rc[c] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid", longint'(out_valid), 0);
    chk(att_l == 0 && att_r == 0, "R1 att", longint'(att_l) + longint'(att_r), 0);
    chk(out_l == 0 && out_r == 0, "R1 outputs", longint'(out_l), 0);
    rst_n = 1'b1;
    idle(2);
    chk(out_valid == 1'b0 && att_l == 0, "R1 after release", longint'(att_l), 0);

    // R2 unity path with attenuation 0
    cfg_en = 1'b1; cfg_max = 3'd0; cfg_cush = 3'd0; cfg_attack = 6'd2; cfg_release = 6'd3;
    send(12345, -54321, "R2");
    send(8388607, -8388608, "R2");
    send(-1, 0, "R2");
    idle(2);

    // R4 attack pacing, R8 right channel unaffected, R3 gain law
    cfg_max = 3'd5; cfg_cush = 3'd7;
    for (int i = 0; i < 20; i++) send(3000000, 100000, "R4 R8 R3");
    // R6 hold band with positive and negative peaks
    for (int i = 0; i < 8; i++) send((i % 2) ? -500000 : 500000, 100000, "R6");
    // R5 release every 4th sample
    for (int i = 0; i < 30; i++) send(1000, -1000, "R5");
    idle(1);

    // R11 no change without strobe
    a0 = att_l; b0 = att_r;
    idle(6);
    chk(int'(att_l) == a0 && int'(att_r) == b0, "R11 idle hold", longint'(att_l), a0);
    chk(out_valid == 1'b0, "R11 idle valid", longint'(out_valid), 0);

    // R5 fastest release
    cfg_release = 6'd0;
    for (int i = 0; i < 12; i++) send(500, 500, "R5 fast");
    idle(1);

    // R7 clamp with full-scale negative input
    cfg_attack = 6'd0; cfg_max = 3'd7; cfg_cush = 3'd7;
    for (int i = 0; i < 70; i++) send(-8388608, -8388608, "R7 R3");
    idle(1);
    chk(att_l == 6'd60 && att_r == 6'd60, "R7 cap", longint'(att_l), 60);

    // R10 disable clears and passes through
    cfg_en = 1'b0;
    send(-8388608, 7777777, "R10");
    send(4242, -4242, "R10");
    idle(1);
    chk(att_l == 0 && att_r == 0, "R10 cleared", longint'(att_l), 0);
    cfg_en = 1'b1;

    // R9 linked: peak on left pulls both down
    cfg_link = 1'b1; cfg_attack = 6'd1; cfg_release = 6'd2; cfg_max = 3'd4; cfg_cush = 3'd6;
    for (int i = 0; i < 16; i++) send(4000000, 10000, "R9 attack");
    for (int i = 0; i < 6; i++) send(100, 3000000, "R9 hold");
    for (int i = 0; i < 20; i++) send(100, -100, "R9 release");
    idle(1);
    chk(att_l == att_r, "R9 equal", longint'(att_l), longint'(att_r));

    // R8 unlinked: peak on right only
    cfg_link = 1'b0;
    for (int i = 0; i < 10; i++) send(50, -4000000, "R8");
    idle(4);
    chk(q.size() == 0, "R11 all outputs seen", q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule